// File: doc/BRIEF.md
# Tagged Byte to Word Reassembler

This block rebuilds 16-bit converter sample words from a stream of 8-bit bus writes. Each byte names its own place in the word: the two most significant bits are a position code and the six bits below them are payload. Because of the code, the three bytes of a word can arrive in any order, and no separate address line is needed.

On each accepted write the block decodes the code and loads the payload into the low, middle or high slice of an assembly register. It also records which slices have arrived in a three-bit mask. When the last missing slice lands, the block presents the finished word with a one-clock valid pulse. That pulse serves as the write request for a downstream sample memory or converter input. Two sticky flags report an illegal position code and a slice that was written twice within one word.

Top module: `tagged_word_rebuild`

## Requirements
- R1: A write is accepted in a clock cycle where `bus_wr` is high and was low in the previous cycle; a strobe held high for several cycles is accepted once only.
- R2: Code 00 in `bus_byte[7:6]` selects the low slice and sets `slice_mask[0]`, code 01 selects the middle slice and sets `slice_mask[1]`, and code 10 selects the high slice and sets `slice_mask[2]`.
- R3: The word is formed as {high payload bits [3:0], middle payload [5:0], low payload [5:0]}, so `word_out[5:0]` is the low slice and `word_out[11:6]` is the middle slice; payload bits [5:4] of a high byte have no effect on `word_out`.
- R4: In the cycle after the accept that completes the mask, `word_valid` is high for exactly one clock with the new `word_out`, and `slice_mask` reads zero in that cycle; `word_out` keeps its value until the next completion.
- R5: The three slices may arrive in any order, and the word completes on whichever slice arrives last.
- R6: A byte with code 11 changes neither the slices nor the mask and raises no `word_valid`; it sets `tag_err`, which stays high until cleared.
- R7: A legal byte whose slice is already marked in the mask replaces that slice's payload, leaves the mask unchanged and sets the sticky `ovr_flag`.
- R8: A one-cycle pulse on `flag_clear` clears both sticky flags; when a flag is set and cleared in the same cycle, it ends up set.
- R9: While `rst` is high at a clock edge, the slices, mask, flags, `word_out` and `word_valid` clear to zero, and any partly assembled word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe from the byte bus |
| bus_byte | input | 8 | Byte: position code in [7:6], payload in [5:0] |
| flag_clear | input | 1 | Clears `tag_err` and `ovr_flag` |
| word_valid | output | 1 | One-clock write request for the finished word |
| word_out | output | 16 | Last finished sample word |
| slice_mask | output | 3 | Slices received for the word in progress |
| tag_err | output | 1 | Sticky: a byte with code 11 was seen |
| ovr_flag | output | 1 | Sticky: a slice was written twice within one word |

## Verification
The hardest case to reach is a long strobe pulse inside a word that also takes a duplicate slice and an illegal byte. A level-sensitive or double-counting design would then complete early or pulse `word_valid` twice. The stimulus holds `bus_wr` high for three to five cycles on several bytes, counts every `word_valid` cycle against one pulse per word, and inserts an illegal and a repeated byte between legal ones. It then checks that the finished word holds only the intended payloads. A clear pulse issued in the same cycle as an illegal byte exercises the set-wins ordering of the flags.

// File: rtl/twr_pkg.sv
`timescale 1ns/1ps
package twr_pkg;

   // names of the position codes for the default 2-bit field
   typedef enum logic [1:0] {
      POS_LOW  = 2'b00,
      POS_MID  = 2'b01,
      POS_HIGH = 2'b10,
      POS_BAD  = 2'b11
   } twr_pos_e;

   function automatic int twr_ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/twr_strobe_edge.sv
`timescale 1ns/1ps
module twr_strobe_edge #(
   parameter bit EDGE_DETECT = 1'b1
) (
   input  logic clk,
   input  logic strobe,
   output logic take
);

   generate
      if (EDGE_DETECT) begin : g_edge
         // previous strobe level; follows the pin even during reset so
         // a strobe held through reset is not taken as a new write
         logic prev_q;
         always_ff @(posedge clk) begin
            prev_q <= strobe;
         end
         assign take = strobe & ~prev_q;
      end else begin : g_level
         assign take = strobe;
      end
   endgenerate

endmodule

// File: rtl/twr_tag_decode.sv
`timescale 1ns/1ps
module twr_tag_decode #(
   parameter int BYTE_W     = 8,
   parameter int TAG_W      = 2,
   parameter int NUM_SLICES = 3
) (
   input  logic                    take,
   input  logic [BYTE_W-1:0]       byte_in,
   output logic [NUM_SLICES-1:0]   hit,
   output logic                    bad,
   output logic [BYTE_W-TAG_W-1:0] payload
);

   localparam int PAY_W = BYTE_W - TAG_W;
   localparam logic [TAG_W-1:0] FIRST_BAD = TAG_W'(NUM_SLICES);

   logic [TAG_W-1:0] tag;

   assign tag     = byte_in[BYTE_W-1 -: TAG_W];
   assign payload = byte_in[PAY_W-1:0];
   assign bad     = take && (tag >= FIRST_BAD);

   generate
      for (genvar i = 0; i < NUM_SLICES; i++) begin : g_hit
         assign hit[i] = take && (tag == TAG_W'(i));
      end
   endgenerate

endmodule

// File: rtl/twr_slice_store.sv
`timescale 1ns/1ps
module twr_slice_store #(
   parameter int PAY_W      = 6,
   parameter int NUM_SLICES = 3,
   parameter int WORD_W     = 16
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NUM_SLICES-1:0] hit,
   input  logic [PAY_W-1:0]      payload,
   output logic [WORD_W-1:0]     acc_nxt,
   output logic [NUM_SLICES-1:0] mask_q,
   output logic                  complete,
   output logic                  redo
);

   logic [WORD_W-1:0]     acc_q;
   logic [NUM_SLICES-1:0] mask_nxt;

   // each slice owns its own field; the top slice may be narrower
   generate
      for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
         localparam int LO = i * PAY_W;
         localparam int SW = ((WORD_W - LO) < PAY_W) ? (WORD_W - LO) : PAY_W;
         assign acc_nxt[LO +: SW] = hit[i] ? payload[SW-1:0] : acc_q[LO +: SW];
      end
   endgenerate

   assign mask_nxt = mask_q | hit;
   // the mask never rests full, so a full next mask implies a new hit
   assign complete = &mask_nxt;
   assign redo     = |(hit & mask_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         mask_q <= '0;
      end else begin
         acc_q  <= acc_nxt;
         mask_q <= complete ? '0 : mask_nxt;
      end
   end

endmodule

// File: rtl/twr_word_out.sv
`timescale 1ns/1ps
module twr_word_out #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              complete,
   input  logic [WORD_W-1:0] word_in,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_out
);

   always_ff @(posedge clk) begin
      if (rst) begin
         word_valid <= 1'b0;
         word_out   <= '0;
      end else begin
         word_valid <= complete;
         if (complete) begin
            word_out <= word_in;
         end
      end
   end

endmodule

// File: rtl/twr_flags.sv
`timescale 1ns/1ps
module twr_flags (
   input  logic clk,
   input  logic rst,
   input  logic bad,
   input  logic redo,
   input  logic clear,
   output logic tag_err,
   output logic ovr_flag
);

   // a new event wins over a clear in the same cycle
   always_ff @(posedge clk) begin
      if (rst) begin
         tag_err  <= 1'b0;
         ovr_flag <= 1'b0;
      end else begin
         tag_err  <= bad  | (tag_err  & ~clear);
         ovr_flag <= redo | (ovr_flag & ~clear);
      end
   end

endmodule

// File: rtl/tagged_word_rebuild.sv
`timescale 1ns/1ps
module tagged_word_rebuild #(
   parameter int BYTE_W      = 8,
   parameter int TAG_W       = 2,
   parameter int WORD_W      = 16,
   parameter bit EDGE_DETECT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  bus_wr,
   input  logic [BYTE_W-1:0]     bus_byte,
   input  logic                  flag_clear,
   output logic                  word_valid,
   output logic [WORD_W-1:0]     word_out,
   output logic [twr_pkg::twr_ceil_div(WORD_W, BYTE_W-TAG_W)-1:0] slice_mask,
   output logic                  tag_err,
   output logic                  ovr_flag
);

   localparam int PAY_W      = BYTE_W - TAG_W;
   localparam int NUM_SLICES = twr_pkg::twr_ceil_div(WORD_W, PAY_W);

   generate
      if (TAG_W < 1 || PAY_W < 1) begin : g_bad_split
         $error("tagged_word_rebuild: byte must hold both a code and payload");
      end
      if (NUM_SLICES >= (1 << TAG_W)) begin : g_no_spare_code
         $error("tagged_word_rebuild: code field needs one unused value");
      end
   endgenerate

   logic                  take;
   logic [NUM_SLICES-1:0] hit;
   logic                  bad;
   logic                  redo;
   logic                  complete;
   logic [PAY_W-1:0]      payload;
   logic [WORD_W-1:0]     acc_nxt;

   twr_strobe_edge #(
      .EDGE_DETECT (EDGE_DETECT)
   ) u_edge (
      .clk    (clk),
      .strobe (bus_wr),
      .take   (take)
   );

   twr_tag_decode #(
      .BYTE_W     (BYTE_W),
      .TAG_W      (TAG_W),
      .NUM_SLICES (NUM_SLICES)
   ) u_decode (
      .take    (take),
      .byte_in (bus_byte),
      .hit     (hit),
      .bad     (bad),
      .payload (payload)
   );

   twr_slice_store #(
      .PAY_W      (PAY_W),
      .NUM_SLICES (NUM_SLICES),
      .WORD_W     (WORD_W)
   ) u_store (
      .clk      (clk),
      .rst      (rst),
      .hit      (hit),
      .payload  (payload),
      .acc_nxt  (acc_nxt),
      .mask_q   (slice_mask),
      .complete (complete),
      .redo     (redo)
   );

   twr_word_out #(
      .WORD_W (WORD_W)
   ) u_out (
      .clk        (clk),
      .rst        (rst),
      .complete   (complete),
      .word_in    (acc_nxt),
      .word_valid (word_valid),
      .word_out   (word_out)
   );

   twr_flags u_flags (
      .clk      (clk),
      .rst      (rst),
      .bad      (bad),
      .redo     (redo),
      .clear    (flag_clear),
      .tag_err  (tag_err),
      .ovr_flag (ovr_flag)
   );

endmodule

// File: rtl/tagged_word_rebuild_chk.sv
`timescale 1ns/1ps
module tagged_word_rebuild_chk #(
   parameter int TAG_W       = 2,
   parameter int WORD_W      = 16,
   parameter int NUM_SLICES  = 3,
   parameter bit EDGE_DETECT = 1'b1
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  bus_wr,
   input logic [TAG_W-1:0]      tag_in,
   input logic                  flag_clear,
   input logic                  word_valid,
   input logic [WORD_W-1:0]     word_out,
   input logic [NUM_SLICES-1:0] slice_mask,
   input logic                  tag_err,
   input logic                  ovr_flag
);

   localparam logic [TAG_W-1:0]      FIRST_BAD = TAG_W'(NUM_SLICES);
   localparam logic [NUM_SLICES-1:0] ONE_BIT   = NUM_SLICES'(1);

   logic prev_wr;
   logic live_q;
   logic take_c;
   logic legal_c;

   always_ff @(posedge clk) begin
      prev_wr <= bus_wr;
      live_q  <= !rst;
   end

   assign take_c  = EDGE_DETECT ? (bus_wr && !prev_wr) : bus_wr;
   assign legal_c = tag_in < FIRST_BAD;

   // R1: a strobe that stays high is not taken again
   a_r1_held_strobe_once: assert property (@(posedge clk) disable iff (rst)
      (EDGE_DETECT && bus_wr && prev_wr) |=> ($stable(slice_mask) && !word_valid));

   // R4: the write request lasts one clock
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
      word_valid |=> !word_valid);

   // R4: the mask is empty while the finished word is presented
   a_r4_mask_empty: assert property (@(posedge clk) disable iff (rst)
      word_valid |-> (slice_mask == '0));

   // R4: the output word only moves with the request
   a_r4_word_held: assert property (@(posedge clk) disable iff (rst)
      (live_q && !word_valid) |-> $stable(word_out));

   // R6: an illegal code leaves the assembly untouched and raises the flag
   a_r6_bad_code_ignored: assert property (@(posedge clk) disable iff (rst)
      (take_c && !legal_c) |=> (tag_err && $stable(slice_mask) && !word_valid));

   // R6: the error flag holds until cleared
   a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
      (tag_err && !flag_clear) |=> tag_err);

   // R7: a repeated slice keeps the mask and raises the overwrite flag
   a_r7_repeat_slice: assert property (@(posedge clk) disable iff (rst)
      (take_c && legal_c && |(slice_mask & (ONE_BIT << tag_in)))
      |=> (ovr_flag && $stable(slice_mask)));

   // R8: a clear with no new event drops the flags
   a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
      (flag_clear && !take_c) |=> (!tag_err && !ovr_flag));

endmodule

bind tagged_word_rebuild tagged_word_rebuild_chk #(
   .TAG_W       (TAG_W),
   .WORD_W      (WORD_W),
   .NUM_SLICES  (NUM_SLICES),
   .EDGE_DETECT (EDGE_DETECT)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .bus_wr     (bus_wr),
   .tag_in     (bus_byte[BYTE_W-1 -: TAG_W]),
   .flag_clear (flag_clear),
   .word_valid (word_valid),
   .word_out   (word_out),
   .slice_mask (slice_mask),
   .tag_err    (tag_err),
   .ovr_flag   (ovr_flag)
);

// File: tb/tagged_word_rebuild_tb.sv
`timescale 1ns/1ps
module tagged_word_rebuild_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_byte = 8'h00;
   logic        flag_clear = 1'b0;
   logic        word_valid;
   logic [15:0] word_out;
   logic [2:0]  slice_mask;
   logic        tag_err;
   logic        ovr_flag;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   tagged_word_rebuild u_dut (
      .clk        (clk),
      .rst        (rst),
      .bus_wr     (bus_wr),
      .bus_byte   (bus_byte),
      .flag_clear (flag_clear),
      .word_valid (word_valid),
      .word_out   (word_out),
      .slice_mask (slice_mask),
      .tag_err    (tag_err),
      .ovr_flag   (ovr_flag)
   );

   // three bytes in arrival order, then the expected word
   localparam logic [39:0] VEC [6] = '{
      {8'h2A, 8'h55, 8'h8C, 16'hC56A},
      {8'hBF, 8'h00, 8'h7F, 16'hFFC0},
      {8'h40, 8'h80, 8'h3F, 16'h003F},
      {8'h3F, 8'h7F, 8'h8F, 16'hFFFF},
      {8'hB0, 8'h41, 8'h01, 16'h0041},
      {8'h15, 8'h89, 8'h6A, 16'h9A95}
   };

   always @(negedge clk) if (!rst && word_valid) pulses++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive one strobe for 'hold' cycles; v and w are sampled in the
   // cycle after the accepting edge, then one low cycle follows
   task automatic put(input logic [7:0] b, input int hold,
                      output logic v, output logic [15:0] w);
      @(negedge clk);
      bus_wr   = 1'b1;
      bus_byte = b;
      @(negedge clk);
      v = word_valid;
      w = word_out;
      for (int k = 1; k < hold; k++) @(negedge clk);
      bus_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic clear_flags();
      @(negedge clk);
      flag_clear = 1'b1;
      @(negedge clk);
      flag_clear = 1'b0;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic        v;
      logic [15:0] w;
      int          p0;

      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 reset word_valid", 32'(word_valid), 0);
      chk("R9 reset word_out", 32'(word_out), 0);
      chk("R9 reset mask", 32'(slice_mask), 0);
      chk("R9 reset flags", 32'({tag_err, ovr_flag}), 0);
      rst = 1'b0;
      @(negedge clk);

      // table walk: R2 R3 R4 R5
      for (int i = 0; i < 6; i++) begin
         logic [7:0]  b0 = VEC[i][39:32];
         logic [7:0]  b1 = VEC[i][31:24];
         logic [7:0]  b2 = VEC[i][23:16];
         logic [15:0] ex = VEC[i][15:0];
         p0 = pulses;
         put(b0, 1, v, w);
         chk("R2 mask after first byte", 32'(slice_mask), 32'(3'b001 << b0[7:6]));
         chk("R4 no request after one byte", 32'(v), 0);
         put(b1, 1, v, w);
         chk("R5 no request after two bytes", 32'(v), 0);
         put(b2, 1, v, w);
         chk("R4 request after last slice", 32'(v), 1);
         chk("R3 assembled word", 32'(w), 32'(ex));
         chk("R4 request lasts one clock", 32'(word_valid), 0);
         chk("R4 mask cleared", 32'(slice_mask), 0);
         chk("R4 one pulse per word", 32'(pulses - p0), 1);
         chk("R7 no overwrite flag", 32'({tag_err, ovr_flag}), 0);
      end

      // R1: long strobes accepted once
      p0 = pulses;
      put(8'h01, 5, v, w);
      chk("R1 held strobe mask", 32'(slice_mask), 32'h1);
      put(8'h42, 3, v, w);
      chk("R1 second held strobe mask", 32'(slice_mask), 32'h3);
      put(8'h83, 4, v, w);
      chk("R1 word after held strobes", 32'(w), 32'h3081);
      chk("R1 single pulse", 32'(pulses - p0), 1);
      chk("R1 no overwrite from held strobe", 32'(ovr_flag), 0);

      // R6: illegal code mid-word
      put(8'h07, 1, v, w);
      put(8'hFF, 1, v, w);
      chk("R6 illegal byte mask", 32'(slice_mask), 32'h1);
      chk("R6 illegal byte request", 32'(v), 0);
      chk("R6 error flag set", 32'(tag_err), 1);
      put(8'h41, 1, v, w);
      put(8'h80, 1, v, w);
      chk("R6 word untouched by illegal byte", 32'(w), 32'h0047);
      chk("R6 error flag sticky", 32'(tag_err), 1);
      clear_flags();
      chk("R8 clear drops error flag", 32'(tag_err), 0);

      // R7: repeated low slice
      put(8'h05, 1, v, w);
      put(8'h0A, 1, v, w);
      chk("R7 overwrite flag", 32'(ovr_flag), 1);
      chk("R7 mask unchanged", 32'(slice_mask), 32'h1);
      put(8'h40, 1, v, w);
      put(8'h80, 1, v, w);
      chk("R7 newer payload kept", 32'(w), 32'h000A);
      clear_flags();
      chk("R8 clear drops overwrite flag", 32'(ovr_flag), 0);

      // R8: set wins over clear in the same cycle
      @(negedge clk);
      flag_clear = 1'b1;
      bus_wr     = 1'b1;
      bus_byte   = 8'hC0;
      @(negedge clk);
      flag_clear = 1'b0;
      bus_wr     = 1'b0;
      @(negedge clk);
      chk("R8 set wins over clear", 32'(tag_err), 1);
      chk("R6 mask empty after illegal byte", 32'(slice_mask), 0);
      clear_flags();

      // R9: reset discards a partial word
      put(8'h01, 1, v, w);
      put(8'h41, 1, v, w);
      put(8'hC5, 1, v, w);
      chk("R2 two slices in mask", 32'(slice_mask), 32'h3);
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk("R9 mask cleared by reset", 32'(slice_mask), 0);
      chk("R9 word cleared by reset", 32'(word_out), 0);
      chk("R9 flags cleared by reset", 32'({tag_err, ovr_flag}), 0);
      put(8'h8F, 1, v, w);
      chk("R9 no stale completion", 32'(v), 0);
      chk("R2 high slice mask bit", 32'(slice_mask), 32'h4);
      put(8'h00, 1, v, w);
      put(8'h40, 1, v, w);
      chk("R5 high slice first", 32'(w), 32'hF000);
      chk("R5 request raised", 32'(v), 1);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule